// File: doc/BRIEF.md
# Fetch Target Queue

This block is a circular queue that keeps one slot for every fetch packet the front-end sends down the pipeline. Each slot holds the packet's fetch PC and a small field of branch-prediction information belonging to that address. When a packet is accepted, the queue reports the slot index it used. Micro-ops carry that index with them, so that while they execute they can recover the PC and prediction field of their packet through a combinational read port.

Slots leave the queue only when the commit stage retires them, oldest first and one per cycle. When a misprediction is resolved, a redirect names the slot of the mispredicting packet. That slot becomes the youngest live entry, every younger slot is discarded, and the slot's prediction field is replaced with the resolved value in the same cycle. The depth must be a power of two.

Top module: `fetch_target_queue`

## Requirements
- R1: After reset the queue is empty: `enqReady` is 1, `enqIdx` is 0 and `rdLive` is 0 for every index.
- R2: An accepted enqueue writes `enqPc` and `enqMeta` into slot `enqIdx`. From the next cycle on, `rdPc`/`rdMeta` return them combinationally when `rdIdx` names that slot.
- R3: `enqReady` is 0 exactly when DEPTH entries are live. An enqueue offered while `enqReady` is 0 changes nothing, even if a dequeue happens in the same cycle.
- R4: `deqValid` removes the oldest live entry. On an empty queue it has no effect.
- R5: An enqueue and a dequeue in the same cycle both take effect, and the live count is unchanged.
- R6: `rdLive` is 1 exactly when `rdIdx` lies in the circular range from the oldest live slot up to, but not including, `enqIdx`.
- R7: A redirect to a live slot k leaves k as the youngest live entry. After the redirect, `enqIdx` is (k+1) mod DEPTH and all slots younger than k read as not live.
- R8: A redirect to a live slot replaces that slot's prediction field with `redirMeta` and leaves its PC unchanged.
- R9: When `redirValid` is 1, a simultaneous enqueue is dropped.
- R10: A redirect that names a slot that is not live changes no state.
- R11: Slot indices wrap modulo DEPTH, so the queue works across any number of wrap-arounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Front-end offers a fetch packet |
| enqPc | input | PC_W | Fetch PC of the offered packet |
| enqMeta | input | META_W | Prediction field of the offered packet |
| enqReady | output | 1 | Queue can accept a packet |
| enqIdx | output | log2(DEPTH) | Slot the next accepted packet will occupy |
| deqValid | input | 1 | Commit retires the oldest entry |
| redirValid | input | 1 | Misprediction redirect |
| redirIdx | input | log2(DEPTH) | Slot of the mispredicting packet |
| redirMeta | input | META_W | Resolved prediction field for that slot |
| rdIdx | input | log2(DEPTH) | Slot read by an executing micro-op |
| rdPc | output | PC_W | PC stored in slot rdIdx |
| rdMeta | output | META_W | Prediction field stored in slot rdIdx |
| rdLive | output | 1 | Slot rdIdx currently holds a live entry |

## Verification
A corrupted head or tail pointer shows at once on `enqIdx` and `enqReady`. In the same cycle, a read sweep over all slots shows the wrong set of live slots on `rdLive`. A wrong write address or a missed metadata update appears on `rdPc`/`rdMeta` as soon as the affected slot is read, which the bench does after every cycle. The bench checks all slots against an arithmetic model after each operation, so a fault shows up within one cycle of the operation that causes it.

// File: rtl/ftq_pkg.sv
package ftq_pkg;
  typedef struct packed {
    logic wrEn;   // write pc and meta at the tail slot
    logic updEn;  // overwrite meta of the redirecting slot
  } ftqStrobes_t;
endpackage

// File: rtl/ftq_store.sv
module ftq_store #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int META_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ftq_pkg::ftqStrobes_t    strobes,
  input  logic [IDX_W-1:0]        wrIdx,
  input  logic [PC_W-1:0]         wrPc,
  input  logic [META_W-1:0]       wrMeta,
  input  logic [IDX_W-1:0]        updIdx,
  input  logic [META_W-1:0]       updMeta,
  input  logic [IDX_W-1:0]        rdIdx,
  output logic [PC_W-1:0]         rdPc,
  output logic [META_W-1:0]       rdMeta
);
  logic [PC_W-1:0]   pcQ   [DEPTH];
  logic [META_W-1:0] metaQ [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrEn) begin
      pcQ[wrIdx]   <= wrPc;
      metaQ[wrIdx] <= wrMeta;
    end
    if (strobes.updEn) begin
      metaQ[updIdx] <= updMeta;
    end
  end

  assign rdPc   = pcQ[rdIdx];
  assign rdMeta = metaQ[rdIdx];

  // R8: resolved meta lands in the named slot
  p_upd_meta_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updEn |=> metaQ[$past(updIdx)] == $past(updMeta));
  // R8: PC of the redirecting slot survives the update
  p_upd_keeps_pc_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.updEn && !strobes.wrEn) |=> pcQ[$past(updIdx)] == $past(pcQ[updIdx]));
  // R9: the controller never writes and updates in one cycle
  p_no_dual_write_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.wrEn && strobes.updEn));
endmodule

// File: rtl/ftq_ctrl.sv
module ftq_ctrl #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 enqValid,
  input  logic                 deqValid,
  input  logic                 redirValid,
  input  logic [IDX_W-1:0]     redirIdx,
  input  logic [IDX_W-1:0]     rdIdx,
  output logic                 enqReady,
  output logic [IDX_W-1:0]     enqIdx,
  output logic                 rdLive,
  output ftq_pkg::ftqStrobes_t strobes
);
  logic [PTR_W-1:0] headQ, tailQ, countW;
  logic [IDX_W-1:0] rdOffW, redirOffW;
  logic             full, empty, redirTake, enqTake, deqTake;

  assign countW    = tailQ - headQ;
  assign full      = (countW == PTR_W'(DEPTH));
  assign empty     = (countW == '0);
  assign rdOffW    = rdIdx - headQ[IDX_W-1:0];
  assign redirOffW = redirIdx - headQ[IDX_W-1:0];

  assign rdLive    = ({1'b0, rdOffW} < countW);
  assign redirTake = redirValid && ({1'b0, redirOffW} < countW);
  assign enqTake   = enqValid && !full && !redirValid;
  assign deqTake   = deqValid && !empty;

  assign enqReady      = !full;
  assign enqIdx        = tailQ[IDX_W-1:0];
  assign strobes.wrEn  = enqTake;
  assign strobes.updEn = redirTake;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ <= '0;
      tailQ <= '0;
    end else begin
      if (redirTake)    tailQ <= headQ + {1'b0, redirOffW} + PTR_W'(1);
      else if (enqTake) tailQ <= tailQ + PTR_W'(1);
      if (deqTake)      headQ <= headQ + PTR_W'(1);
    end
  end

  // R3: occupancy never exceeds the depth
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    countW <= PTR_W'(DEPTH));
  // R3: a full queue stays full without dequeue or redirect
  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rstN)
    (full && !deqValid && !redirValid) |=> countW == PTR_W'(DEPTH));
  // R4: dequeue on empty does nothing
  p_deq_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !enqValid) |=> countW == '0);
  // R7: redirect truncates to the named slot
  p_redir_trunc_r7: assert property (@(posedge clk) disable iff (!rstN)
    (redirTake && !deqTake) |=> countW == PTR_W'($past(redirOffW)) + PTR_W'(1));
  // R9: tail never advances by an enqueue during a redirect
  p_redir_drops_enq_r9: assert property (@(posedge clk) disable iff (!rstN)
    (redirValid && !redirTake) |=> tailQ == $past(tailQ));
endmodule

// File: rtl/fetch_target_queue.sv
module fetch_target_queue #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int META_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enqValid,
  input  logic [PC_W-1:0]   enqPc,
  input  logic [META_W-1:0] enqMeta,
  output logic              enqReady,
  output logic [IDX_W-1:0]  enqIdx,
  input  logic              deqValid,
  input  logic              redirValid,
  input  logic [IDX_W-1:0]  redirIdx,
  input  logic [META_W-1:0] redirMeta,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [PC_W-1:0]   rdPc,
  output logic [META_W-1:0] rdMeta,
  output logic              rdLive
);
  ftq_pkg::ftqStrobes_t strobes;

  ftq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .deqValid(deqValid),
    .redirValid(redirValid), .redirIdx(redirIdx), .rdIdx(rdIdx),
    .enqReady(enqReady), .enqIdx(enqIdx), .rdLive(rdLive), .strobes(strobes)
  );

  ftq_store #(.DEPTH(DEPTH), .PC_W(PC_W), .META_W(META_W)) uStore (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrIdx(enqIdx), .wrPc(enqPc), .wrMeta(enqMeta),
    .updIdx(redirIdx), .updMeta(redirMeta),
    .rdIdx(rdIdx), .rdPc(rdPc), .rdMeta(rdMeta)
  );
endmodule

// File: tb/sim_fetch_target_queue.sv
`timescale 1ns/100ps
module sim_fetch_target_queue;
  localparam int D = 4, PW = 16, MW = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic enqValid = 0, deqValid = 0, redirValid = 0;
  logic [PW-1:0] enqPc = '0;
  logic [MW-1:0] enqMeta = '0, redirMeta = '0;
  logic [1:0] redirIdx = '0, rdIdx = '0;
  logic enqReady, rdLive;
  logic [1:0] enqIdx;
  logic [PW-1:0] rdPc;
  logic [MW-1:0] rdMeta;

  always #4 clk = ~clk;

  fetch_target_queue #(.DEPTH(D), .PC_W(PW), .META_W(MW)) u0 (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqPc(enqPc), .enqMeta(enqMeta),
    .enqReady(enqReady), .enqIdx(enqIdx), .deqValid(deqValid),
    .redirValid(redirValid), .redirIdx(redirIdx), .redirMeta(redirMeta),
    .rdIdx(rdIdx), .rdPc(rdPc), .rdMeta(rdMeta), .rdLive(rdLive)
  );

  int nCmp = 0, nBad = 0;
  int mHead = 0, mCount = 0;
  logic [PW-1:0] mPc [D];
  logic [MW-1:0] mMeta [D];
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit mLive(int idx);
    return ((idx - mHead + D) % D) < mCount;
  endfunction

  // sweep every slot through the read port
  task automatic checkAll(string req);
    for (int i = 0; i < D; i++) begin
      rdIdx = 2'(i);
      #0.2;
      chk("R6", "rdLive", 32'(rdLive), 32'(mLive(i)));
      if (mLive(i)) begin
        chk(req, "rdPc", 32'(rdPc), 32'(mPc[i]));
        chk(req, "rdMeta", 32'(rdMeta), 32'(mMeta[i]));
      end
    end
  endtask

  task automatic cyc(bit e, logic [PW-1:0] p, logic [MW-1:0] m, bit d,
                     bit r, int ri, logic [MW-1:0] rm, string req);
    int old;
    enqValid = e; enqPc = p; enqMeta = m; deqValid = d;
    redirValid = r; redirIdx = 2'(ri); redirMeta = rm;
    #1;
    chk(req, "enqReady", 32'(enqReady), 32'(mCount < D));
    chk(req, "enqIdx", 32'(enqIdx), 32'((mHead + mCount) % D));
    @(posedge clk);
    old = mCount;
    if (r) begin
      if (mLive(ri)) begin
        mMeta[ri] = rm;
        mCount = ((ri - mHead + D) % D) + 1;
      end
    end else if (e && mCount < D) begin
      mPc[(mHead + mCount) % D] = p;
      mMeta[(mHead + mCount) % D] = m;
      mCount++;
    end
    if (d && old > 0) begin
      mHead = (mHead + 1) % D;
      mCount--;
    end
    @(negedge clk);
    enqValid = 0; deqValid = 0; redirValid = 0;
    checkAll(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    #1;
    chk("R1", "enqReady", 32'(enqReady), 32'd1);
    chk("R1", "enqIdx", 32'(enqIdx), 32'd0);
    checkAll("R1");
    // R2/R3 fill to full, then offer one more
    for (int i = 0; i < D; i++) cyc(1, 16'h1000 + 16'(i), 4'(i + 1), 0, 0, 0, 0, "R2");
    cyc(1, 16'hdead, 4'hf, 0, 0, 0, 0, "R3");
    // R3 enqueue while full with dequeue in same cycle: only dequeue
    cyc(1, 16'hbeef, 4'he, 1, 0, 0, 0, "R3");
    // R4 dequeue, R5 enqueue with dequeue
    cyc(0, 0, 0, 1, 0, 0, 0, "R4");
    cyc(1, 16'h2000, 4'h7, 1, 0, 0, 0, "R5");
    cyc(1, 16'h2001, 4'h8, 1, 0, 0, 0, "R11");
    // R8/R7 redirect to the second oldest live slot
    cyc(0, 0, 0, 0, 1, (mHead + 1) % D, 4'h9, "R8");
    cyc(0, 0, 0, 0, 1, (mHead + 1) % D, 4'h3, "R7");
    // R9 redirect drops enqueue
    cyc(1, 16'h3333, 4'h2, 0, 1, mHead, 4'h5, "R9");
    // R10 redirect to a non-live slot
    cyc(0, 0, 0, 0, 1, (mHead + 2) % D, 4'hc, "R10");
    // R4 drain then dequeue on empty
    cyc(0, 0, 0, 1, 0, 0, 0, "R4");
    cyc(0, 0, 0, 1, 0, 0, 0, "R4");
    cyc(1, 16'h4444, 4'h1, 0, 0, 0, 0, "R2");
    // R11 mixed traffic over many wrap-arounds
    lfsr = 16'hace1;
    for (int n = 0; n < 600; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], lfsr ^ 16'(n), lfsr[7:4], lfsr[1] & lfsr[2],
          (lfsr[3:1] == 3'b101), int'(lfsr[9:8]), lfsr[13:10], "R11");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule